// File: doc/BRIEF.md
# G.711 Two-Direction Compander

This block sits between a codec's linear sample path and its 8-bit serial word path. It converts in both directions. On the capture side, linear two's-complement samples are compressed to 8-bit G.711 codes. On the playback side, 8-bit codes are expanded back to linear samples. Each direction has its own 2-bit mode input that selects bypass, mu-law or A-law. A bypassed direction returns its linear word unchanged.

A compressed code occupies the eight most significant bits of the `LIN_W`-bit word, and the bits below it are zero. An expanded sample is placed in the most significant sixteen bits of the linear output.

Each direction samples its mode input together with its own valid strobe. That same cycle's mode decides how the sample is treated. An output flag reports whether 8-bit word mode is active. The flag reflects the modes taken by the most recent sample of each direction.

Top module: `g711_compander`

## Requirements
- R1: While reset is asserted and after it is released, before any sample arrives, both output valids, both output words and `byte_mode_o` are 0.
- R2: Mode 2'b00 (off) and mode 2'b01 (reserved) behave identically. The output word equals the input word of the same sample, bit for bit, in both directions.
- R3: Mode 2'b10 on capture takes the top 14 input bits as a signed value and uses its magnitude (negation for negative values). It adds 33 and finds the segment e, the smallest e with sum < 64·2^e. The mantissa is bits e+4..e+1 of the sum. The code {sign 0, e, mantissa} is inverted in all 8 bits, so positive samples get bit 7 = 1. The code goes into bits [LIN_W-1:LIN_W-8], and the lower bits are 0.
- R4: Mode 2'b11 on capture takes the top 13 input bits as a signed value. The magnitude is the value itself for non-negative input and -value-1 for negative input. Segment e is the smallest e with magnitude < 32·2^e. The mantissa is bits 4..1 of the magnitude for e < 2, and bits e+3..e otherwise. Bit 7 is 1 for non-negative input. The code is then XORed with 8'h55 and placed as in R3.
- R5: Mode 2'b10 on playback inverts code bits [LIN_W-1:LIN_W-8] to get sign s (bit 7), segment e and mantissa m. The output is ±4·((2m+33)·2^e − 33), and it is negative when s = 1.
- R6: Mode 2'b11 on playback XORs the code with 8'h55 to get s, e and m. The magnitude is 8·(2m+1) for e = 0 and 8·(2m+33)·2^(e−1) otherwise. The output is positive when s = 1.
- R7: Each output valid is high exactly one clock after its input valid. Each output word changes only in that cycle and holds otherwise.
- R8: `byte_mode_o` is 1 when bit 1 of the mode sampled with the latest capture sample or the latest playback sample is 1, and 0 otherwise.
- R9: A mode input change without a valid strobe affects neither output word nor `byte_mode_o`.
- R10: In mode 2'b10, capture magnitudes of 8159 or more saturate to the largest code: 8'h80 for positive input and 8'h00 for negative input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_mode_i | input | 2 | Capture mode, sampled with `cap_valid_i` |
| cap_valid_i | input | 1 | Capture sample strobe |
| cap_lin_i | input | LIN_W | Linear capture sample |
| cap_valid_o | output | 1 | Capture result strobe |
| cap_word_o | output | LIN_W | Compressed code in the MSBs, or the bypassed sample |
| pb_mode_i | input | 2 | Playback mode, sampled with `pb_valid_i` |
| pb_valid_i | input | 1 | Playback word strobe |
| pb_word_i | input | LIN_W | Code in the MSBs, or the linear word in bypass |
| pb_valid_o | output | 1 | Playback result strobe |
| pb_lin_o | output | LIN_W | Expanded or bypassed linear sample |
| byte_mode_o | output | 1 | 8-bit word mode active |

## Verification
Every result is due on the first rising edge after its strobe: the data, the output valid and the 8-bit mode flag all move together one clock later. The bench drives each stimulus half a period before a rising edge. It compares each output half a period after that edge with a reference computed from the formulas above. In cycles without a strobe, the same comparison confirms that the words and the flag keep their previous values.

// File: rtl/g711_pkg.sv
package g711_pkg;

   typedef enum logic [1:0] {
      CMP_OFF  = 2'b00,
      CMP_RSVD = 2'b01,
      CMP_ULAW = 2'b10,
      CMP_ALAW = 2'b11
   } cmp_mode_e;

   localparam int MU_BIAS = 33;
   localparam int MU_CLIP = 8159;
   localparam int EXP_W   = 16;

   // 14-bit signed linear to inverted mu-law code
   function automatic logic [7:0] ulaw_enc(input logic [13:0] s);
      int v, mag, b, seg;
      logic [7:0] mask;
      v = int'($signed(s));
      if (v < 0) begin
         mag  = -v;
         mask = 8'h7F;
      end else begin
         mag  = v;
         mask = 8'hFF;
      end
      if (mag > MU_CLIP) mag = MU_CLIP;
      b   = mag + MU_BIAS;
      seg = 8;
      for (int i = 7; i >= 0; i--) begin
         if (b < (64 << i)) seg = i;
      end
      if (seg == 8) return 8'h7F ^ mask;
      return 8'((seg << 4) | ((b >> (seg + 1)) & 15)) ^ mask;
   endfunction

   // 13-bit signed linear to even-bit-inverted A-law code
   function automatic logic [7:0] alaw_enc(input logic [12:0] s);
      int v, mag, seg, man;
      logic [7:0] mask;
      v = int'($signed(s));
      if (v >= 0) begin
         mag  = v;
         mask = 8'hD5;
      end else begin
         mag  = -v - 1;
         mask = 8'h55;
      end
      seg = 8;
      for (int i = 7; i >= 0; i--) begin
         if (mag < (32 << i)) seg = i;
      end
      if (seg == 8) return 8'h7F ^ mask;
      man = (seg < 2) ? ((mag >> 1) & 15) : ((mag >> seg) & 15);
      return 8'((seg << 4) | man) ^ mask;
   endfunction

   function automatic logic [15:0] ulaw_dec(input logic [7:0] c);
      logic [7:0] u;
      int t;
      u = ~c;
      t = (int'(u[3:0]) << 3) + 132;
      t = t << u[6:4];
      return u[7] ? 16'(132 - t) : 16'(t - 132);
   endfunction

   function automatic logic [15:0] alaw_dec(input logic [7:0] c);
      logic [7:0] a;
      int t, seg;
      a   = c ^ 8'h55;
      t   = int'(a[3:0]) << 4;
      seg = int'(a[6:4]);
      if (seg == 0) begin
         t = t + 8;
      end else begin
         t = t + 264;
         t = t << (seg - 1);
      end
      return a[7] ? 16'(t) : 16'(-t);
   endfunction

endpackage

// File: rtl/g711_enc.sv
module g711_enc
   import g711_pkg::*;
#(
   parameter int LIN_W = 16
) (
   input  logic [1:0]       mode_i,
   input  logic [LIN_W-1:0] lin_i,
   output logic [LIN_W-1:0] word_o
);
   localparam int PAD_W = LIN_W - 8;

   cmp_mode_e  mode;
   logic [7:0] mu_code;
   logic [7:0] a_code;

   assign mode    = cmp_mode_e'(mode_i);
   assign mu_code = ulaw_enc(lin_i[LIN_W-1 -: 14]);
   assign a_code  = alaw_enc(lin_i[LIN_W-1 -: 13]);

   always_comb begin
      case (mode)
         CMP_ULAW: word_o = {mu_code, {PAD_W{1'b0}}};
         CMP_ALAW: word_o = {a_code, {PAD_W{1'b0}}};
         default:  word_o = lin_i;
      endcase
   end
endmodule

// File: rtl/g711_dec.sv
module g711_dec
   import g711_pkg::*;
#(
   parameter int LIN_W = 16
) (
   input  logic [1:0]       mode_i,
   input  logic [LIN_W-1:0] word_i,
   output logic [LIN_W-1:0] lin_o
);
   cmp_mode_e        mode;
   logic [EXP_W-1:0] mu_lin;
   logic [EXP_W-1:0] a_lin;
   logic [LIN_W-1:0] mu_ext;
   logic [LIN_W-1:0] a_ext;

   assign mode   = cmp_mode_e'(mode_i);
   assign mu_lin = ulaw_dec(word_i[LIN_W-1 -: 8]);
   assign a_lin  = alaw_dec(word_i[LIN_W-1 -: 8]);

   generate
      if (LIN_W == EXP_W) begin : g_exact
         assign mu_ext = mu_lin;
         assign a_ext  = a_lin;
      end else begin : g_pad
         assign mu_ext = {mu_lin, {(LIN_W-EXP_W){1'b0}}};
         assign a_ext  = {a_lin, {(LIN_W-EXP_W){1'b0}}};
      end
   endgenerate

   always_comb begin
      case (mode)
         CMP_ULAW: lin_o = mu_ext;
         CMP_ALAW: lin_o = a_ext;
         default:  lin_o = word_i;
      endcase
   end
endmodule

// File: rtl/g711_lane.sv
module g711_lane #(
   parameter int LIN_W      = 16,
   parameter bit IS_CAPTURE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid_i,
   input  logic [1:0]       mode_i,
   input  logic [LIN_W-1:0] in_word_i,
   output logic             out_valid_o,
   output logic [LIN_W-1:0] out_word_o,
   output logic             byte_sel_o
);
   logic [LIN_W-1:0] conv;

   generate
      if (IS_CAPTURE) begin : g_compress
         g711_enc #(.LIN_W(LIN_W)) u_enc (
            .mode_i (mode_i),
            .lin_i  (in_word_i),
            .word_o (conv)
         );
      end else begin : g_expand
         g711_dec #(.LIN_W(LIN_W)) u_dec (
            .mode_i (mode_i),
            .word_i (in_word_i),
            .lin_o  (conv)
         );
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid_o <= 1'b0;
         out_word_o  <= '0;
         byte_sel_o  <= 1'b0;
      end else begin
         out_valid_o <= in_valid_i;
         if (in_valid_i) begin
            out_word_o <= conv;
            byte_sel_o <= mode_i[1];
         end
      end
   end
endmodule

// File: rtl/g711_compander.sv
module g711_compander #(
   parameter int LIN_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       cap_mode_i,
   input  logic             cap_valid_i,
   input  logic [LIN_W-1:0] cap_lin_i,
   output logic             cap_valid_o,
   output logic [LIN_W-1:0] cap_word_o,
   input  logic [1:0]       pb_mode_i,
   input  logic             pb_valid_i,
   input  logic [LIN_W-1:0] pb_word_i,
   output logic             pb_valid_o,
   output logic [LIN_W-1:0] pb_lin_o,
   output logic             byte_mode_o
);
   generate
      if (LIN_W < g711_pkg::EXP_W) begin : g_bad_width
         $error("g711_compander: LIN_W must be at least 16");
      end
   endgenerate

   logic cap_byte;
   logic pb_byte;

   g711_lane #(.LIN_W(LIN_W), .IS_CAPTURE(1'b1)) u_cap (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid_i  (cap_valid_i),
      .mode_i      (cap_mode_i),
      .in_word_i   (cap_lin_i),
      .out_valid_o (cap_valid_o),
      .out_word_o  (cap_word_o),
      .byte_sel_o  (cap_byte)
   );

   g711_lane #(.LIN_W(LIN_W), .IS_CAPTURE(1'b0)) u_pb (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid_i  (pb_valid_i),
      .mode_i      (pb_mode_i),
      .in_word_i   (pb_word_i),
      .out_valid_o (pb_valid_o),
      .out_word_o  (pb_lin_o),
      .byte_sel_o  (pb_byte)
   );

   assign byte_mode_o = cap_byte | pb_byte;
endmodule

// File: rtl/g711_compander_sva.sv
module g711_compander_sva #(
   parameter int LIN_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       cap_mode_i,
   input logic             cap_valid_i,
   input logic [LIN_W-1:0] cap_lin_i,
   input logic             cap_valid_o,
   input logic [LIN_W-1:0] cap_word_o,
   input logic [1:0]       pb_mode_i,
   input logic             pb_valid_i,
   input logic [LIN_W-1:0] pb_word_i,
   input logic             pb_valid_o,
   input logic [LIN_W-1:0] pb_lin_o,
   input logic             byte_mode_o
);
   localparam logic [LIN_W-1:0] MAX_POS = {1'b0, {(LIN_W-1){1'b1}}};

   AST_CAP_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      cap_valid_i |=> cap_valid_o); // R7
   AST_CAP_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_valid_i |=> !cap_valid_o); // R7
   AST_PB_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      pb_valid_i |=> pb_valid_o); // R7
   AST_PB_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !pb_valid_i |=> !pb_valid_o); // R7
   AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_valid_i |=> $stable(cap_word_o)); // R7
   AST_PB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !pb_valid_i |=> $stable(pb_lin_o)); // R7
   AST_CAP_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
      cap_valid_i && !cap_mode_i[1] |=> cap_word_o == $past(cap_lin_i)); // R2
   AST_PB_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
      pb_valid_i && !pb_mode_i[1] |=> pb_lin_o == $past(pb_word_i)); // R2
   AST_CODE_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      cap_valid_i && cap_mode_i[1] |=> cap_word_o[LIN_W-9:0] == '0); // R3
   AST_MU_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
      cap_valid_i && cap_mode_i == 2'b10 && cap_lin_i == MAX_POS
      |=> cap_word_o[LIN_W-1 -: 8] == 8'h80); // R10
   AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      cap_valid_i && cap_mode_i[1] |=> byte_mode_o); // R8
   AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_valid_i && !pb_valid_i |=> $stable(byte_mode_o)); // R9
endmodule

bind g711_compander g711_compander_sva #(.LIN_W(LIN_W)) u_sva (
   .clk         (clk),
   .rst_n       (rst_n),
   .cap_mode_i  (cap_mode_i),
   .cap_valid_i (cap_valid_i),
   .cap_lin_i   (cap_lin_i),
   .cap_valid_o (cap_valid_o),
   .cap_word_o  (cap_word_o),
   .pb_mode_i   (pb_mode_i),
   .pb_valid_i  (pb_valid_i),
   .pb_word_i   (pb_word_i),
   .pb_valid_o  (pb_valid_o),
   .pb_lin_o    (pb_lin_o),
   .byte_mode_o (byte_mode_o)
);

// File: tb/g711_compander_bench.sv
module g711_compander_bench;
   localparam int W = 16;

   logic         clk = 1'b0;
   logic         rst_n = 1'b1;
   logic [1:0]   cap_mode_i = 2'b00;
   logic         cap_valid_i = 1'b0;
   logic [W-1:0] cap_lin_i = '0;
   logic         cap_valid_o;
   logic [W-1:0] cap_word_o;
   logic [1:0]   pb_mode_i = 2'b00;
   logic         pb_valid_i = 1'b0;
   logic [W-1:0] pb_word_i = '0;
   logic         pb_valid_o;
   logic [W-1:0] pb_lin_o;
   logic         byte_mode_o;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   // model state
   logic         m_cv = 1'b0, m_pv = 1'b0, m_fc = 1'b0, m_fp = 1'b0;
   logic [W-1:0] m_cd = '0, m_pd = '0;

   always #2 clk = ~clk;

   g711_compander #(.LIN_W(W)) u_g711_compander (
      .clk(clk), .rst_n(rst_n),
      .cap_mode_i(cap_mode_i), .cap_valid_i(cap_valid_i), .cap_lin_i(cap_lin_i),
      .cap_valid_o(cap_valid_o), .cap_word_o(cap_word_o),
      .pb_mode_i(pb_mode_i), .pb_valid_i(pb_valid_i), .pb_word_i(pb_word_i),
      .pb_valid_o(pb_valid_o), .pb_lin_o(pb_lin_o),
      .byte_mode_o(byte_mode_o)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [W-1:0] ref_cap(input logic [1:0] m, input logic [W-1:0] x);
      int v, mag, e, mant, code;
      bit neg;
      if (m == 2'b10) begin
         v   = int'($signed(x)) >>> 2;
         neg = (v < 0);
         mag = neg ? -v : v;
         if (mag >= 8159) begin
            code = 127;
         end else begin
            e = 0;
            while ((mag + 33) >= (64 << e)) e++;
            mant = ((mag + 33) >> (e + 1)) % 16;
            code = e * 16 + mant;
         end
         code = neg ? (code ^ 127) : (code ^ 255);
         return {code[7:0], 8'h00};
      end else if (m == 2'b11) begin
         v   = int'($signed(x)) >>> 3;
         neg = (v < 0);
         mag = neg ? (-v - 1) : v;
         e = 0;
         while (mag >= (32 << e)) e++;
         mant = (e < 2) ? ((mag / 2) % 16) : ((mag >> e) % 16);
         code = e * 16 + mant;
         if (!neg) code = code + 128;
         code = code ^ 85;
         return {code[7:0], 8'h00};
      end
      return x;
   endfunction

   function automatic logic [W-1:0] ref_pb(input logic [1:0] m, input logic [W-1:0] x);
      logic [7:0] c;
      int e, mm, mag;
      if (m == 2'b10) begin
         c   = ~x[15:8];
         e   = int'(c[6:4]);
         mm  = int'(c[3:0]);
         mag = (((2 * mm + 33) << e) - 33) * 4;
         return c[7] ? W'(-mag) : W'(mag);
      end else if (m == 2'b11) begin
         c   = x[15:8] ^ 8'h55;
         e   = int'(c[6:4]);
         mm  = int'(c[3:0]);
         mag = (e == 0) ? (2 * mm + 1) * 8 : ((2 * mm + 33) << (e - 1)) * 8;
         return c[7] ? W'(mag) : W'(-mag);
      end
      return x;
   endfunction

   function automatic string cap_tag(input logic [1:0] m);
      if (m == 2'b10) return "R3";
      if (m == 2'b11) return "R4";
      return "R2";
   endfunction

   function automatic string pb_tag(input logic [1:0] m);
      if (m == 2'b10) return "R5";
      if (m == 2'b11) return "R6";
      return "R2";
   endfunction

   // called at a falling edge; returns at the next falling edge after comparing
   task automatic step(input bit cv, input logic [1:0] cm, input logic [W-1:0] cd,
                       input bit pv, input logic [1:0] pm, input logic [W-1:0] pd);
      cap_valid_i = cv; cap_mode_i = cm; cap_lin_i = cd;
      pb_valid_i  = pv; pb_mode_i  = pm; pb_word_i = pd;
      m_cv = cv;
      m_pv = pv;
      if (cv) begin m_cd = ref_cap(cm, cd); m_fc = cm[1]; end
      if (pv) begin m_pd = ref_pb(pm, pd);  m_fp = pm[1]; end
      @(posedge clk);
      @(negedge clk);
      chk(cap_valid_o == m_cv, "R7", "cap valid", 32'(cap_valid_o), 32'(m_cv));
      chk(pb_valid_o == m_pv, "R7", "pb valid", 32'(pb_valid_o), 32'(m_pv));
      chk(cap_word_o == m_cd, cv ? cap_tag(cm) : "R7", "cap word", 32'(cap_word_o), 32'(m_cd));
      chk(pb_lin_o == m_pd, pv ? pb_tag(pm) : "R7", "pb word", 32'(pb_lin_o), 32'(m_pd));
      chk(byte_mode_o == (m_fc | m_fp), "R8", "byte flag", 32'(byte_mode_o), 32'(m_fc | m_fp));
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL R7 watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] keep;
      #1 rst_n = 1'b0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(cap_valid_o == 1'b0, "R1", "cap valid", 32'(cap_valid_o), 0);
      chk(pb_valid_o == 1'b0, "R1", "pb valid", 32'(pb_valid_o), 0);
      chk(cap_word_o == '0, "R1", "cap word", 32'(cap_word_o), 0);
      chk(pb_lin_o == '0, "R1", "pb word", 32'(pb_lin_o), 0);
      chk(byte_mode_o == 1'b0, "R1", "byte flag", 32'(byte_mode_o), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(byte_mode_o == 1'b0 && cap_word_o == '0, "R1", "after release", 32'(cap_word_o), 0);

      // directed literals
      step(1, 2'b10, 16'h0000, 1, 2'b10, 16'hFF00);
      chk(cap_word_o == 16'hFF00, "R3", "mu zero", 32'(cap_word_o), 32'hFF00);
      chk(pb_lin_o == 16'h0000, "R5", "mu decode FF", 32'(pb_lin_o), 0);
      chk(byte_mode_o == 1'b1, "R8", "flag mu", 32'(byte_mode_o), 1);
      step(1, 2'b10, 16'hFFFC, 1, 2'b11, 16'hD500);
      chk(cap_word_o[15:8] == 8'h7E, "R3", "mu minus one", 32'(cap_word_o[15:8]), 32'h7E);
      chk(pb_lin_o == 16'd8, "R6", "A decode D5", 32'(pb_lin_o), 8);
      step(1, 2'b11, 16'h0000, 0, 2'b00, 16'h0000);
      chk(cap_word_o == 16'hD500, "R4", "A zero", 32'(cap_word_o), 32'hD500);
      chk(pb_valid_o == 1'b0, "R7", "pb idle", 32'(pb_valid_o), 0);
      step(1, 2'b11, 16'hFFF8, 0, 2'b00, 16'h0000);
      chk(cap_word_o == 16'h5500, "R4", "A minus one", 32'(cap_word_o), 32'h5500);
      step(1, 2'b10, 16'h7FFF, 0, 2'b00, 16'h0000);
      chk(cap_word_o[15:8] == 8'h80, "R10", "mu max positive", 32'(cap_word_o[15:8]), 32'h80);
      step(1, 2'b10, 16'h8000, 0, 2'b00, 16'h0000);
      chk(cap_word_o[15:8] == 8'h00, "R10", "mu max negative", 32'(cap_word_o[15:8]), 0);
      step(1, 2'b10, 16'h7F7C, 0, 2'b00, 16'h0000);
      chk(cap_word_o[15:8] == 8'h80, "R10", "mu mag 8159", 32'(cap_word_o[15:8]), 32'h80);
      step(1, 2'b01, 16'h1234, 1, 2'b01, 16'hABCD);
      chk(cap_word_o == 16'h1234, "R2", "reserved cap", 32'(cap_word_o), 32'h1234);
      chk(pb_lin_o == 16'hABCD, "R2", "reserved pb", 32'(pb_lin_o), 32'hABCD);
      chk(byte_mode_o == 1'b0, "R8", "flag clear", 32'(byte_mode_o), 0);
      step(0, 2'b11, 16'h0000, 0, 2'b10, 16'h0000);
      step(0, 2'b10, 16'h7777, 0, 2'b11, 16'h5555);
      chk(byte_mode_o == 1'b0, "R9", "flag without strobe", 32'(byte_mode_o), 0);
      chk(cap_word_o == 16'h1234, "R9", "cap word without strobe", 32'(cap_word_o), 32'h1234);
      chk(pb_lin_o == 16'hABCD, "R9", "pb word without strobe", 32'(pb_lin_o), 32'hABCD);
      step(1, 2'b00, 16'h5555, 1, 2'b00, 16'h8001);
      chk(cap_word_o == 16'h5555 && pb_lin_o == 16'h8001, "R2", "off both",
          32'(cap_word_o), 32'h5555);

      // R3 R4 R5 R6 R7 R8 R9 sweep of the full playback code space
      for (int c = 0; c < 256; c++) begin
         step(1'b0, 2'b00, 16'h0000, 1'b1, (c % 2 == 0) ? 2'b10 : 2'b11, {8'(c), 8'h00});
         step(1'b0, 2'b00, 16'h0000, 1'b1, (c % 2 == 0) ? 2'b11 : 2'b10, {8'(c), 8'h00});
      end

      // mixed random traffic
      for (int i = 0; i < 4000; i++) begin
         logic [W-1:0] cd, pd;
         int sel;
         sel = int'($urandom % 8);
         cd  = W'($urandom);
         pd  = W'($urandom);
         if (sel == 0) cd = 16'h7FFF;
         if (sel == 1) cd = 16'h8000;
         if (sel == 2) cd = W'(int'($urandom % 512) - 256);
         step(($urandom % 4) != 0, 2'($urandom), cd, ($urandom % 4) != 0, 2'($urandom), pd);
      end
      keep = cap_word_o;
      step(0, 2'b11, 16'h1111, 0, 2'b10, 16'h2222);
      chk(cap_word_o == keep, "R9", "final hold", 32'(cap_word_o), 32'(keep));

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule